// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block gathers interrupt requests for a small CPU core and picks the one to service next. Peripheral sources each present a status flag and an enable bit. A source asks for service only when both bits are high. Several flag/enable pairs may share one interrupt number. A software trap, an illegal-opcode event and a non-maskable external request arrive as one-cycle event inputs. Every request is latched into a sticky pending register, and each pending bit stays set until that interrupt is taken.

The choice of winner is combinational, made from the pending register, the two condition-code mask bits of the CPU (I and X) and a writable order table. A fixed rule covers the special sources. The table covers the maskable ones. Alongside the interrupt number, the block gives the vector-fetch address, which is a writable base plus twice the number, and says which mask bit the CPU must set once the interrupt is entered. The core pulses the accept input for one cycle to take the current winner. That pulse clears the winner's pending bit, reports a fixed entry cost of 14 cycles and advances a running count of serviced interrupts.

Top module: `irq_arbiter`

## Requirements
- R1: Peripheral pair p reaches pending only when flag_i[p] and enab_i[p] are both 1 in the same cycle. With the default map, pairs 0 to 3 all share interrupt number 0, and pairs 4, 5, 6 and 7 map to numbers 1, 2, 3 and 4.
- R2: Pending bits are sticky. A bit is cleared only by an accept while that number is the winner. If a new request for the same number arrives in the cycle of the clear, the bit stays set.
- R3: The software trap (number 15) wins over everything, and the illegal-opcode event (number 14) wins over everything else. Both ignore the I and X mask bits.
- R4: Next in rank is the non-maskable request (number 13), which is taken when xmask_i is 0. While it is pending and xmask_i is 1, valid_o is 0, even when lower requests are pending and imask_i is 0.
- R5: While imask_i is 1, no maskable source (numbers 0 to 12) is selected.
- R6: Maskable sources are scanned in slot order of the order table, and the pending source in the lowest slot wins. At reset, slot k holds number k. A write with ord_we_i stores ord_src_i into slot ord_slot_i.
- R7: vec_o equals the vector base plus 2 times id_o. The base resets to 0xFFC0 and is loaded from base_i when base_we_i is 1.
- R8: When valid_o is 1, set_x_o is 1 if the winner is number 13, and set_i_o is 1 for any other winner. Both are 0 when valid_o is 0.
- R9: cost_o shows 14 in a cycle where accept_i and valid_o are both 1, and 0 otherwise. count_o increments by one on each such accept.
- R10: valid_o is 0 when nothing can be serviced. An accept while valid_o is 0 changes no pending bit and leaves count_o as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_i | input | N_PAIR | Peripheral status flags |
| enab_i | input | N_PAIR | Matching peripheral enable bits |
| swi_i | input | 1 | Software trap event |
| ill_i | input | 1 | Illegal-opcode event |
| nmi_i | input | 1 | Non-maskable external request |
| imask_i | input | 1 | CPU I mask bit |
| xmask_i | input | 1 | CPU X mask bit |
| accept_i | input | 1 | One-cycle strobe that takes the current winner |
| ord_we_i | input | 1 | Order table write enable |
| ord_slot_i | input | IDW | Order table slot to write |
| ord_src_i | input | IDW | Interrupt number stored in that slot |
| base_we_i | input | 1 | Vector base write enable |
| base_i | input | 16 | New vector base |
| valid_o | output | 1 | A winner exists |
| id_o | output | IDW | Winning interrupt number |
| vec_o | output | 16 | Vector-fetch address of the winner |
| set_i_o | output | 1 | CPU must set I on entry |
| set_x_o | output | 1 | CPU must set X on entry |
| cost_o | output | 8 | Entry cycle cost reported on accept |
| count_o | output | CNT_W | Number of accepted interrupts |

## Verification
A request, an order-table write or a base write is sampled at one clock edge and shows on valid_o, id_o, vec_o and the set outputs right after that edge. A change of imask_i or xmask_i acts on the selection in the same cycle, with no register in between. cost_o is combinational from accept_i, so the bench reads it a moment after raising the strobe, while the cleared pending bit and the new count_o only show after the following edge. Every input is driven shortly after a rising edge, and every output is sampled later in the same cycle, well clear of the next edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int VA_W = 16;
  localparam logic [VA_W-1:0] BASE_RST = 16'hFFC0;
  localparam int ENTRY_COST = 14;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_SWI  = 3'd1,
    WK_ILL  = 3'd2,
    WK_NMI  = 3'd3,
    WK_MASK = 3'd4
  } win_kind_e;

  // vector slot address: two bytes per interrupt number
  function automatic logic [VA_W-1:0] vec_addr(input logic [VA_W-1:0] base,
                                               input int unsigned num);
    return base + VA_W'(num * 2);
  endfunction
endpackage

// File: rtl/irq_collect.sv
module irq_collect #(
  parameter int N_SRC  = 16,
  parameter int N_PAIR = 8,
  parameter int IDW    = $clog2(N_SRC),
  parameter logic [N_PAIR*IDW-1:0] PAIR_MAP = '0,
  parameter int SWI_ID = 15,
  parameter int ILL_ID = 14,
  parameter int NMI_ID = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PAIR-1:0] flag_i,
  input  logic [N_PAIR-1:0] enab_i,
  input  logic              swi_i,
  input  logic              ill_i,
  input  logic              nmi_i,
  input  logic [N_SRC-1:0]  clr_i,
  output logic [N_SRC-1:0]  pend_o
);
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] pend_q;

  always_comb begin
    req = '0;
    for (int p = 0; p < N_PAIR; p++) begin
      if (flag_i[p] && enab_i[p]) req[PAIR_MAP[p*IDW +: IDW]] = 1'b1;
    end
    req[SWI_ID] = req[SWI_ID] | swi_i;
    req[ILL_ID] = req[ILL_ID] | ill_i;
    req[NMI_ID] = req[NMI_ID] | nmi_i;
  end

  // new request beats a clear of the same bit
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | req;
  end

  assign pend_o = pend_q;

  // R1
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair_chk
    pair_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_i[p] && enab_i[p]) |=> pend_q[PAIR_MAP[p*IDW +: IDW]]);
  end

  // R2
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q & ~clr_i) != '0) |=>
      ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/irq_order.sv
module irq_order #(
  parameter int N_SRC = 16,
  parameter int IDW   = $clog2(N_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we_i,
  input  logic [IDW-1:0]            slot_i,
  input  logic [IDW-1:0]            src_i,
  output logic [N_SRC-1:0][IDW-1:0] tbl_o
);
  logic [N_SRC-1:0][IDW-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < N_SRC; k++) tbl_q[k] <= IDW'(k);
    end else if (we_i) begin
      tbl_q[slot_i] <= src_i;
    end
  end

  assign tbl_o = tbl_q;

  // R6
  order_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (tbl_q[$past(slot_i)] == $past(src_i)));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int IDW    = $clog2(N_SRC),
  parameter int SWI_ID = 15,
  parameter int ILL_ID = 14,
  parameter int NMI_ID = 13
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_SRC-1:0]          pend_i,
  input  logic [N_SRC-1:0][IDW-1:0] tbl_i,
  input  logic                      imask_i,
  input  logic                      xmask_i,
  output logic                      valid_o,
  output logic [IDW-1:0]            id_o,
  output win_kind_e                 kind_o
);
  localparam logic [N_SRC-1:0] SPECIAL =
    (N_SRC'(1) << SWI_ID) | (N_SRC'(1) << ILL_ID) | (N_SRC'(1) << NMI_ID);

  logic [N_SRC-1:0] pend_m;

  always_comb begin
    pend_m = pend_i & ~SPECIAL;
    kind_o = WK_NONE;
    id_o   = '0;
    if (pend_i[SWI_ID]) begin
      kind_o = WK_SWI;
      id_o   = IDW'(SWI_ID);
    end else if (pend_i[ILL_ID]) begin
      kind_o = WK_ILL;
      id_o   = IDW'(ILL_ID);
    end else if (pend_i[NMI_ID]) begin
      if (!xmask_i) begin
        kind_o = WK_NMI;
        id_o   = IDW'(NMI_ID);
      end
    end else if (!imask_i) begin
      // walk downward so the lowest slot is written last and wins
      for (int k = N_SRC - 1; k >= 0; k--) begin
        if (pend_m[tbl_i[k]]) begin
          kind_o = WK_MASK;
          id_o   = tbl_i[k];
        end
      end
    end
  end

  assign valid_o = (kind_o != WK_NONE);

  // R3
  swi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i[SWI_ID] |-> (valid_o && id_o == IDW'(SWI_ID)));

  // R4
  nmi_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i[NMI_ID] && xmask_i && !pend_i[SWI_ID] && !pend_i[ILL_ID]) |-> !valid_o);

  // R5
  imask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_i && valid_o) |-> (kind_o != WK_MASK));

  // R10
  none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !valid_o);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 16,
  parameter int N_PAIR = 8,
  parameter int IDW    = $clog2(N_SRC),
  parameter logic [N_PAIR*IDW-1:0] PAIR_MAP = 32'h4321_0000,
  parameter int SWI_ID = 15,
  parameter int ILL_ID = 14,
  parameter int NMI_ID = 13,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PAIR-1:0] flag_i,
  input  logic [N_PAIR-1:0] enab_i,
  input  logic              swi_i,
  input  logic              ill_i,
  input  logic              nmi_i,
  input  logic              imask_i,
  input  logic              xmask_i,
  input  logic              accept_i,
  input  logic              ord_we_i,
  input  logic [IDW-1:0]    ord_slot_i,
  input  logic [IDW-1:0]    ord_src_i,
  input  logic              base_we_i,
  input  logic [15:0]       base_i,
  output logic              valid_o,
  output logic [IDW-1:0]    id_o,
  output logic [15:0]       vec_o,
  output logic              set_i_o,
  output logic              set_x_o,
  output logic [7:0]        cost_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [N_SRC-1:0]          pend;
  logic [N_SRC-1:0]          clr;
  logic [N_SRC-1:0][IDW-1:0] tbl;
  win_kind_e                 kind;
  logic                      take;
  logic [15:0]               base_q;
  logic [CNT_W-1:0]          count_q;

  irq_collect #(
    .N_SRC(N_SRC), .N_PAIR(N_PAIR), .IDW(IDW), .PAIR_MAP(PAIR_MAP),
    .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enab_i(enab_i),
    .swi_i(swi_i), .ill_i(ill_i), .nmi_i(nmi_i), .clr_i(clr), .pend_o(pend)
  );

  irq_order #(.N_SRC(N_SRC), .IDW(IDW)) u_order (
    .clk(clk), .rst_n(rst_n), .we_i(ord_we_i), .slot_i(ord_slot_i),
    .src_i(ord_src_i), .tbl_o(tbl)
  );

  irq_select #(
    .N_SRC(N_SRC), .IDW(IDW), .SWI_ID(SWI_ID), .ILL_ID(ILL_ID), .NMI_ID(NMI_ID)
  ) u_select (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .tbl_i(tbl), .imask_i(imask_i),
    .xmask_i(xmask_i), .valid_o(valid_o), .id_o(id_o), .kind_o(kind)
  );

  assign take = accept_i && valid_o;
  assign clr  = take ? (N_SRC'(1) << id_o) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= BASE_RST;
      count_q <= '0;
    end else begin
      if (base_we_i) base_q <= base_i;
      if (take)      count_q <= count_q + 1'b1;
    end
  end

  assign vec_o   = vec_addr(base_q, int'(id_o));
  assign set_x_o = valid_o && (kind == WK_NMI);
  assign set_i_o = valid_o && (kind != WK_NMI);
  assign cost_o  = take ? 8'(ENTRY_COST) : 8'd0;
  assign count_o = count_q;

  // R8
  set_bits_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_i_o, set_x_o}) && (valid_o == (set_i_o || set_x_o)));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (count_o == $past(count_o) + 1'b1));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(count_o));
endmodule

// File: tb/test_irq_arbiter.sv
module test_irq_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  flag_i = '0, enab_i = '0;
  logic        swi_i = 0, ill_i = 0, nmi_i = 0, imask_i = 0, xmask_i = 0;
  logic        accept_i = 0, ord_we_i = 0, base_we_i = 0;
  logic [3:0]  ord_slot_i = '0, ord_src_i = '0;
  logic [15:0] base_i = '0;
  logic        valid_o, set_i_o, set_x_o;
  logic [3:0]  id_o;
  logic [15:0] vec_o, count_o;
  logic [7:0]  cost_o;

  int checks = 0, errors = 0, exp_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_arbiter i_irq_arbiter (
    .clk(clk), .rst_n(rst_n), .flag_i(flag_i), .enab_i(enab_i),
    .swi_i(swi_i), .ill_i(ill_i), .nmi_i(nmi_i), .imask_i(imask_i),
    .xmask_i(xmask_i), .accept_i(accept_i), .ord_we_i(ord_we_i),
    .ord_slot_i(ord_slot_i), .ord_src_i(ord_src_i), .base_we_i(base_we_i),
    .base_i(base_i), .valid_o(valid_o), .id_o(id_o), .vec_o(vec_o),
    .set_i_o(set_i_o), .set_x_o(set_x_o), .cost_o(cost_o), .count_o(count_o)
  );

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_win(input string tag, input int id, input int vec,
                         input int si, input int sx);
    chk({tag, " valid"}, int'(valid_o), 1);
    chk({tag, " id"}, int'(id_o), id);
    chk({tag, " vec"}, int'(vec_o), vec);
    chk({tag, " set_i"}, int'(set_i_o), si);
    chk({tag, " set_x"}, int'(set_x_o), sx);
  endtask

  // take the current winner; R9 cost and count
  task automatic do_accept(input string tag);
    accept_i = 1'b1;
    #1;
    chk({tag, " R9 cost"}, int'(cost_o), 14);
    tick();
    accept_i = 1'b0;
    exp_cnt++;
    chk({tag, " R9 count"}, int'(count_o), exp_cnt);
  endtask

  task automatic pulse_pairs(input logic [7:0] f, input logic [7:0] e);
    flag_i = f; enab_i = e;
    tick();
    flag_i = '0; enab_i = '0;
  endtask

  task automatic t_reset;
    chk("R10 reset valid", int'(valid_o), 0);
    chk("R9 reset count", int'(count_o), 0);
    chk("R9 reset cost", int'(cost_o), 0);
  endtask

  task automatic t_pair_gate;
    pulse_pairs(8'h20, 8'h00);
    chk("R1 flag only", int'(valid_o), 0);
    pulse_pairs(8'h00, 8'h20);
    chk("R1 enable only", int'(valid_o), 0);
    pulse_pairs(8'h20, 8'h20);
    chk_win("R1 pair5", 2, 16'hFFC4, 1, 0);
    tick();
    chk_win("R2 sticky", 2, 16'hFFC4, 1, 0);
    // same-number request in the clear cycle survives
    flag_i = 8'h20; enab_i = 8'h20;
    do_accept("R2 clash");
    flag_i = '0; enab_i = '0;
    chk_win("R2 request wins clear", 2, 16'hFFC4, 1, 0);
    do_accept("R2 drain");
    chk("R2 cleared", int'(valid_o), 0);
  endtask

  task automatic t_shared;
    pulse_pairs(8'h06, 8'h0F);
    chk_win("R1 shared id0", 0, 16'hFFC0, 1, 0);
    do_accept("R1 shared");
    chk("R1 shared single bit", int'(valid_o), 0);
  endtask

  task automatic t_special;
    imask_i = 1; xmask_i = 1;
    swi_i = 1; ill_i = 1; nmi_i = 1; flag_i = 8'h10; enab_i = 8'h10;
    tick();
    swi_i = 0; ill_i = 0; nmi_i = 0; flag_i = '0; enab_i = '0;
    chk_win("R3 swi masked", 15, 16'hFFDE, 1, 0);
    do_accept("R3 swi");
    chk_win("R3 ill masked", 14, 16'hFFDC, 1, 0);
    do_accept("R3 ill");
    chk("R4 nmi blocked by X", int'(valid_o), 0);
    imask_i = 0;
    #1;
    chk("R4 nmi stalls lower", int'(valid_o), 0);
    accept_i = 1; #1;
    chk("R10 idle accept cost", int'(cost_o), 0);
    tick();
    accept_i = 0;
    chk("R10 idle accept count", int'(count_o), exp_cnt);
    xmask_i = 0;
    #1;
    chk_win("R4 R8 nmi taken", 13, 16'hFFDA, 0, 1);
    do_accept("R4 nmi");
    imask_i = 1;
    #1;
    chk("R5 I blocks maskable", int'(valid_o), 0);
    imask_i = 0;
    #1;
    chk_win("R5 maskable after I", 1, 16'hFFC2, 1, 0);
    do_accept("R5 id1");
    chk("R10 empty", int'(valid_o), 0);
  endtask

  task automatic t_order;
    pulse_pairs(8'h90, 8'h90);
    chk_win("R6 identity order", 1, 16'hFFC2, 1, 0);
    ord_we_i = 1; ord_slot_i = 4'd0; ord_src_i = 4'd4;
    tick();
    ord_slot_i = 4'd4; ord_src_i = 4'd0;
    tick();
    ord_we_i = 0;
    chk_win("R6 swapped order", 4, 16'hFFC8, 1, 0);
    do_accept("R6 id4");
    chk_win("R6 next", 1, 16'hFFC2, 1, 0);
    do_accept("R6 id1");
  endtask

  task automatic t_base;
    base_we_i = 1; base_i = 16'h1000;
    tick();
    base_we_i = 0;
    pulse_pairs(8'h40, 8'h40);
    chk_win("R7 new base", 3, 16'h1006, 1, 0);
    do_accept("R7 id3");
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    t_reset();
    t_pair_gate();
    t_shared();
    t_special();
    t_order();
    t_base();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule